// File: doc/BRIEF.md
# DDR command decoder and bank tracker

This block watches the command pins of a double-data-rate SDRAM and samples them on every rising clock edge. It turns chip select, the three command strobes, clock enable, the bank bits and the address bus into one registered one-hot command strobe. Alongside that strobe it presents the sampled bank, row, column and auto-precharge bit.

It keeps state for each of the four banks: whether the bank is open, which row is open in it, and whether the bank's most recent read asked for auto precharge. It also tracks the kind of the last data burst on the bus, so that a burst-terminate command can be judged.

Commands that break the bank or burst rules raise a one-cycle violation pulse and leave all tracked state untouched. Mode-register loads are stored in a base register and an extended register. A read-latency output is derived from the stored CAS-latency field, and it grows by one clock when the registered-module input is set. A monitor or a controller can sit on a memory bus and use these outputs to check the traffic.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: All outputs are registered and update at the clock edge that samples the command. `cmd_oh` has exactly one bit set after each edge, at the bit index given below. With `cs_n` high the command is NOP (bit 0) whatever the other pins are. With `cs_n` low, {ras_n,cas_n,we_n} decodes as 111 NOP (bit 0), 011 ACTIVE (bit 1), 101 READ (bit 2), 100 WRITE (bit 3), 110 BURST TERMINATE (bit 4), 010 PRECHARGE (bit 5) and 000 LOAD MODE (bit 8).
- R2: The refresh encoding 001 gives auto refresh (bit 6) when `cke` is high and self-refresh entry (bit 7) when `cke` is low. Bank state and the address-derived fields other than the echo fields are not affected.
- R3: ACTIVE to a closed bank sets that bank's bit in `bank_open` and stores `addr` as its row, in `open_rows` slice [bank*13 +: 13]. ACTIVE to an open bank pulses `viol` and changes nothing.
- R4: READ or WRITE to a bank that is closed, or that has an auto precharge still pending, pulses `viol` and changes no state. A legal READ stores `addr[10]` in that bank's bit of `rd_ap`.
- R5: PRECHARGE with `addr[10]` low closes only the bank on `ba`.
- R6: PRECHARGE with `addr[10]` high closes all banks whatever `ba` is, and cancels any pending auto precharge. PRECHARGE never raises `viol`.
- R7: A legal READ or WRITE with `addr[10]` high closes its bank exactly AP_CYC (default 4) edges after the edge that sampled it.
- R8: BURST TERMINATE is legal only when the last legal burst command was a READ with `addr[10]` low, and a legal terminate clears that record. In every other case it pulses `viol`, including after a WRITE, after an auto-precharge READ, or after reset.
- R9: LOAD MODE with `ba`=00 stores `addr` in `mode_reg`, and with `ba`=01 it stores `addr` in `ext_mode_reg`. With `ba`=10 or 11 it pulses `viol` and stores nothing.
- R10: `rd_lat_half` is the read latency in half clocks. It is taken from `mode_reg[6:4]` as it stood before the edge: 010 gives 4, 110 gives 5, 011 gives 6, and any other value gives 0. When the value is non-zero and `reg_mode` is high, 2 is added.
- R11: A synchronous active-high `rst` clears every output to zero, including the bank state, both mode registers, the burst record and `viol`.
- R12: `cmd_bank` echoes `ba`, `cmd_row` echoes `addr`, and `cmd_col` echoes `addr[9:0]`. `cmd_ap` equals `addr[10]` for READ, WRITE and PRECHARGE, and is 0 for every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or op-code bus |
| reg_mode | input | 1 | Registered-module mode, adds one clock to latency |
| cmd_oh | output | 9 | One-hot decoded command |
| cmd_bank | output | 2 | Sampled bank |
| cmd_row | output | 13 | Sampled address as a row |
| cmd_col | output | 10 | Sampled column |
| cmd_ap | output | 1 | Auto-precharge or precharge-all bit |
| viol | output | 1 | Protocol violation pulse |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 52 | Open row per bank, 13 bits each |
| rd_ap | output | 4 | Per-bank: last read used auto precharge |
| mode_reg | output | 13 | Base mode register |
| ext_mode_reg | output | 13 | Extended mode register |
| rd_lat_half | output | 4 | Read latency in half clocks |

## Verification
The assertions assume that every command pin, `ba` and `addr` hold known values at each rising edge, and that a rule which depends on prior state is only judged once that state comes from a clean reset. The stimulus drives every input on the falling edge, always to defined values, with `cs_n` and `cke` combinations restricted to the decoded set. It deliberately issues illegal sequences as well as legal ones, so that the violation paths and the ignore-on-violation behaviour are exercised under the same timing as legal traffic.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  localparam int CMD_N = 9;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_WR   = 4'd3,
    C_BST  = 4'd4,
    C_PRE  = 4'd5,
    C_AREF = 4'd6,
    C_SREF = 4'd7,
    C_LMR  = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    LB_NONE = 2'd0,
    LB_RD   = 2'd1,
    LB_RDAP = 2'd2,
    LB_WR   = 2'd3
  } burst_e;

  // CAS latency field to half-clock latency; registered mode adds a clock
  function automatic logic [3:0] cl_half(input logic [2:0] code, input logic regd);
    logic [3:0] base;
    case (code)
      3'b010:  base = 4'd4;
      3'b110:  base = 4'd5;
      3'b011:  base = 4'd6;
      default: base = 4'd0;
    endcase
    if (base != 4'd0 && regd) base = base + 4'd2;
    return base;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  // R1 R2: pin decode
  always_comb begin
    cmd = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = cke ? C_AREF : C_SREF;
        default: cmd = C_LMR;
      endcase
    end
  end

endmodule

// File: rtl/ddr_cmd_rules.sv
module ddr_cmd_rules
  import ddr_trk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic [NB-1:0]   open_i,
  input  logic [NB-1:0]   busy_i,
  input  burst_e          last_i,
  output logic            viol,
  output logic [NB-1:0]   act_en,
  output logic [NB-1:0]   acc_en,
  output logic [NB-1:0]   pre_en,
  output logic            rd_ok,
  output logic            wr_ok,
  output logic            bst_ok,
  output logic            lmr_ok
);

  logic sel_open, sel_busy;

  assign sel_open = open_i[ba];
  assign sel_busy = busy_i[ba];

  always_comb begin
    viol   = 1'b0;
    act_en = '0;
    acc_en = '0;
    pre_en = '0;
    rd_ok  = 1'b0;
    wr_ok  = 1'b0;
    bst_ok = 1'b0;
    lmr_ok = 1'b0;
    case (cmd)
      C_ACT: begin // R3
        if (sel_open) viol = 1'b1;
        else act_en[ba] = 1'b1;
      end
      C_RD: begin // R4
        if (!sel_open || sel_busy) viol = 1'b1;
        else begin
          rd_ok      = 1'b1;
          acc_en[ba] = 1'b1;
        end
      end
      C_WR: begin // R4
        if (!sel_open || sel_busy) viol = 1'b1;
        else begin
          wr_ok      = 1'b1;
          acc_en[ba] = 1'b1;
        end
      end
      C_BST: begin // R8
        if (last_i == LB_RD) bst_ok = 1'b1;
        else viol = 1'b1;
      end
      C_PRE: begin // R5 R6
        if (a10) pre_en = '1;
        else pre_en[ba] = 1'b1;
      end
      C_LMR: begin // R9
        if (ba[BA_W-1:1] == '0) lmr_ok = 1'b1;
        else viol = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W  = 13,
  parameter int AP_CYC = 4,
  localparam int CNT_W = $clog2(AP_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_en,
  input  logic             acc_en,
  input  logic             acc_ap,
  input  logic             rd_en,
  input  logic             pre_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rdap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o <= 1'b0;
      row_o  <= '0;
      cnt_q  <= '0;
    end else if (pre_en) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (act_en) begin
      open_o <= 1'b1;
      row_o  <= row_in;
    end else if (acc_en && acc_ap) begin
      cnt_q <= CNT_W'(AP_CYC);
    end else if (cnt_q == CNT_W'(1)) begin
      open_o <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdap_o <= 1'b0;
    else if (rd_en) rdap_o <= acc_ap;
  end

  assign busy_o = (cnt_q != '0);

  // R7
  pend_open_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> open_o);

  // R7
  ap_close_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(1) && !pre_en) |=> !open_o);

endmodule

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
  import ddr_trk_pkg::*;
#(
  parameter int OP_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            sel_ext,
  input  logic [OP_W-1:0] op,
  input  logic            reg_mode,
  output logic [OP_W-1:0] mr_q,
  output logic [OP_W-1:0] emr_q,
  output logic [3:0]      lat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_q  <= '0;
      emr_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr_en && !sel_ext) mr_q  <= op;
      if (wr_en && sel_ext)  emr_q <= op;
      lat_q <= cl_half(mr_q[6:4], reg_mode);
    end
  end

  // R9
  mr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !sel_ext) |=> $stable(mr_q));

  // R9
  emr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel_ext) |=> $stable(emr_q));

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int  BA_W     = 2,
  parameter int  ROW_W    = 13,
  parameter int  WIDE_COL = 0,
  parameter int  AP_CYC   = 4,
  localparam int NB       = 1 << BA_W,
  localparam int COL_W    = (WIDE_COL != 0) ? 11 : 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BA_W-1:0]     ba,
  input  logic [ROW_W-1:0]    addr,
  input  logic                reg_mode,
  output logic [CMD_N-1:0]    cmd_oh,
  output logic [BA_W-1:0]     cmd_bank,
  output logic [ROW_W-1:0]    cmd_row,
  output logic [COL_W-1:0]    cmd_col,
  output logic                cmd_ap,
  output logic                viol,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_rows,
  output logic [NB-1:0]       rd_ap,
  output logic [ROW_W-1:0]    mode_reg,
  output logic [ROW_W-1:0]    ext_mode_reg,
  output logic [3:0]          rd_lat_half
);

  cmd_e            cmd;
  burst_e          last_q;
  logic            viol_now;
  logic [NB-1:0]   act_en, acc_en, pre_en, busy;
  logic            rd_ok, wr_ok, bst_ok, lmr_ok;
  logic [COL_W-1:0] col_now;

  ddr_cmd_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  ddr_cmd_rules #(.NB(NB), .BA_W(BA_W)) u_rules (
    .cmd    (cmd),
    .ba     (ba),
    .a10    (addr[10]),
    .open_i (bank_open),
    .busy_i (busy),
    .last_i (last_q),
    .viol   (viol_now),
    .act_en (act_en),
    .acc_en (acc_en),
    .pre_en (pre_en),
    .rd_ok  (rd_ok),
    .wr_ok  (wr_ok),
    .bst_ok (bst_ok),
    .lmr_ok (lmr_ok)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ddr_bank_slot #(.ROW_W(ROW_W), .AP_CYC(AP_CYC)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .act_en (act_en[b]),
      .acc_en (acc_en[b]),
      .acc_ap (addr[10]),
      .rd_en  (acc_en[b] && rd_ok),
      .pre_en (pre_en[b]),
      .row_in (addr),
      .open_o (bank_open[b]),
      .busy_o (busy[b]),
      .row_o  (open_rows[b*ROW_W +: ROW_W]),
      .rdap_o (rd_ap[b])
    );
  end

  ddr_mode_regs #(.OP_W(ROW_W)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (lmr_ok),
    .sel_ext  (ba[0]),
    .op       (addr),
    .reg_mode (reg_mode),
    .mr_q     (mode_reg),
    .emr_q    (ext_mode_reg),
    .lat_q    (rd_lat_half)
  );

  if (WIDE_COL != 0) begin : g_wide
    assign col_now = {addr[11], addr[9:0]};
  end else begin : g_narrow
    assign col_now = addr[9:0];
  end

  // R8: record of the last burst on the bus
  always_ff @(posedge clk) begin
    if (rst) last_q <= LB_NONE;
    else if (rd_ok) last_q <= addr[10] ? LB_RDAP : LB_RD;
    else if (wr_ok) last_q <= LB_WR;
    else if (bst_ok) last_q <= LB_NONE;
  end

  // R1 R12: registered command outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_oh   <= '0;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      viol     <= 1'b0;
    end else begin
      cmd_oh   <= CMD_N'(1) << cmd;
      cmd_bank <= ba;
      cmd_row  <= addr;
      cmd_col  <= col_now;
      cmd_ap   <= addr[10] && (cmd == C_RD || cmd == C_WR || cmd == C_PRE);
      viol     <= viol_now;
    end
  end

  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT && bank_open[ba]) |=> viol);

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_PRE && addr[10]) |=> (bank_open == '0 && !viol));

  // R8
  bst_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_BST && last_q != LB_RD) |=> viol);

  // R1
  oh_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_oh));

endmodule

// File: tb/ddr_cmd_tracker_bench.sv
module ddr_cmd_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        reg_mode = 1'b0;
  logic [8:0]  cmd_oh;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [9:0]  cmd_col;
  logic        cmd_ap, viol;
  logic [3:0]  bank_open, rd_ap;
  logic [51:0] open_rows;
  logic [12:0] mode_reg, ext_mode_reg;
  logic [3:0]  rd_lat_half;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_open[4], m_row[4], m_rdap[4], m_cnt[4];
  int m_last; // 0 none, 1 read, 2 read with ap, 3 write
  int m_mr, m_emr, m_lat;
  int e_oh, e_viol, e_bank, e_row, e_col, e_ap;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_tracker u_ddr_cmd_tracker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .reg_mode(reg_mode), .cmd_oh(cmd_oh),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .viol(viol), .bank_open(bank_open), .open_rows(open_rows), .rd_ap(rd_ap),
    .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg), .rd_lat_half(rd_lat_half)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lat_of(int mr, bit rm);
    int code = (mr >> 4) & 7;
    int v = (code == 2) ? 4 : (code == 6) ? 5 : (code == 3) ? 6 : 0;
    if (v != 0 && rm) v += 2;
    return v;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_rdap[b] = 0; m_cnt[b] = 0;
    end
    m_last = 0; m_mr = 0; m_emr = 0; m_lat = 0;
    e_oh = 0; e_viol = 0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0;
  endtask

  task automatic compare(string tag);
    longint rows = 0;
    int opn = 0, rda = 0;
    for (int b = 0; b < 4; b++) begin
      rows |= longint'(m_row[b]) << (13 * b);
      opn  |= m_open[b] << b;
      rda  |= m_rdap[b] << b;
    end
    chk(tag, "cmd_oh", cmd_oh, e_oh);
    chk(tag, "viol", viol, e_viol);
    chk(tag, "bank_open", bank_open, opn);
    chk(tag, "open_rows", open_rows, rows);
    chk(tag, "rd_ap", rd_ap, rda);
    chk(tag, "mode_reg", mode_reg, m_mr);
    chk(tag, "ext_mode_reg", ext_mode_reg, m_emr);
    chk(tag, "rd_lat_half", rd_lat_half, m_lat);
    chk("R12", "cmd_bank", cmd_bank, e_bank);
    chk("R12", "cmd_row", cmd_row, e_row);
    chk("R12", "cmd_col", cmd_col, e_col);
    chk("R12", "cmd_ap", cmd_ap, e_ap);
  endtask

  // drive one command, update the model after the edge, compare at negedge
  task automatic step(string tag, bit csn, bit [2:0] rcw, bit ck, int bav, int adr);
    int c, v, ap, busy;
    cs_n = csn; {ras_n, cas_n, we_n} = rcw; cke = ck; ba = bav[1:0]; addr = adr[12:0];
    @(posedge clk);
    if (csn) c = 0;
    else case (rcw)
      3'b111: c = 0; 3'b011: c = 1; 3'b101: c = 2; 3'b100: c = 3;
      3'b110: c = 4; 3'b010: c = 5; 3'b001: c = ck ? 6 : 7;
      default: c = 8;
    endcase
    ap = (adr >> 10) & 1;
    busy = (m_cnt[bav] != 0);
    v = 0;
    if (c == 1 && m_open[bav]) v = 1;
    if ((c == 2 || c == 3) && (!m_open[bav] || busy)) v = 1;
    if (c == 4 && m_last != 1) v = 1;
    if (c == 8 && bav > 1) v = 1;
    m_lat = lat_of(m_mr, reg_mode);
    for (int b = 0; b < 4; b++)
      if (m_cnt[b] > 0) begin
        if (m_cnt[b] == 1) m_open[b] = 0;
        m_cnt[b]--;
      end
    if (!v) begin
      case (c)
        1: begin m_open[bav] = 1; m_row[bav] = adr & 'h1fff; end
        2: begin m_rdap[bav] = ap; m_last = ap ? 2 : 1; if (ap) m_cnt[bav] = AP; end
        3: begin m_last = 3; if (ap) m_cnt[bav] = AP; end
        4: m_last = 0;
        5: for (int b = 0; b < 4; b++)
             if (ap || b == bav) begin m_open[b] = 0; m_cnt[b] = 0; end
        8: if (bav == 0) m_mr = adr & 'h1fff; else m_emr = adr & 'h1fff;
        default: ;
      endcase
    end
    e_oh = 1 << c; e_viol = v; e_bank = bav; e_row = adr & 'h1fff;
    e_col = adr & 'h3ff; e_ap = (c == 2 || c == 3 || c == 5) ? ap : 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1;
    cs_n = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    compare(tag);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    do_reset("R11");
    // R1: deselect and nop
    step("R1", 1, 3'b000, 1, 2, 'h1555);
    step("R1", 0, 3'b111, 1, 3, 'h0aaa);
    // R9 / R10: mode loads and latency
    step("R9", 0, 3'b000, 1, 0, 'h0022);
    step("R10", 0, 3'b111, 1, 0, 0);
    reg_mode = 1'b1;
    step("R10", 0, 3'b111, 1, 0, 0);
    step("R9", 0, 3'b000, 1, 1, 'h0005);
    step("R9", 0, 3'b000, 1, 2, 'h1fff);
    step("R9", 0, 3'b000, 1, 3, 'h1234);
    step("R9", 0, 3'b000, 1, 0, 'h0062);
    step("R10", 0, 3'b111, 1, 0, 0);
    reg_mode = 1'b0;
    step("R10", 0, 3'b000, 1, 0, 'h0032);
    step("R10", 0, 3'b111, 1, 0, 0);
    step("R10", 0, 3'b111, 1, 0, 0);
    // R3: activate
    step("R3", 0, 3'b011, 1, 0, 'h1abc);
    step("R3", 0, 3'b011, 1, 0, 'h0123);
    // R8: terminate after reset with no read
    step("R8", 0, 3'b110, 1, 0, 0);
    // R4: access closed bank, then legal read
    step("R4", 0, 3'b101, 1, 1, 'h0010);
    step("R4", 0, 3'b100, 1, 2, 'h0010);
    step("R4", 0, 3'b101, 1, 0, 'h03ff);
    step("R8", 0, 3'b110, 1, 0, 0);
    step("R8", 0, 3'b110, 1, 0, 0);
    step("R8", 0, 3'b100, 1, 0, 'h0155);
    step("R8", 0, 3'b110, 1, 0, 0);
    // R7: auto precharge read
    step("R7", 0, 3'b011, 1, 2, 'h0777);
    step("R7", 0, 3'b101, 1, 2, 'h0401);
    step("R4", 0, 3'b100, 1, 2, 'h0402);
    step("R8", 0, 3'b110, 1, 0, 0);
    step("R7", 0, 3'b111, 1, 0, 0);
    step("R7", 0, 3'b111, 1, 0, 0);
    step("R7", 0, 3'b111, 1, 0, 0);
    step("R7", 0, 3'b011, 1, 2, 'h0888);
    // R6: write with ap, cancelled by precharge all
    step("R6", 0, 3'b011, 1, 3, 'h1001);
    step("R6", 0, 3'b100, 1, 3, 'h0400);
    step("R6", 0, 3'b010, 1, 1, 'h0400);
    step("R6", 0, 3'b111, 1, 0, 0);
    step("R6", 0, 3'b111, 1, 0, 0);
    step("R6", 0, 3'b111, 1, 0, 0);
    step("R6", 0, 3'b111, 1, 0, 0);
    // R5: single bank precharge
    step("R5", 0, 3'b011, 1, 0, 'h0042);
    step("R5", 0, 3'b011, 1, 1, 'h0043);
    step("R5", 0, 3'b010, 1, 1, 'h0000);
    step("R5", 0, 3'b010, 1, 3, 'h0000);
    // R2: refresh forms
    step("R2", 0, 3'b001, 1, 3, 'h1fff);
    step("R2", 0, 3'b001, 0, 2, 'h0400);
    step("R1", 0, 3'b111, 1, 0, 0);
    // R11: reset with state present
    do_reset("R11");
    step("R11", 0, 3'b111, 1, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule